// File: doc/BRIEF.md
# IO Channel Freeze/Thaw Sequencer

This block moves a group of IO channels between a frozen state and a working (thawed) state. It does this by driving each channel's pad control lines one group at a time, in a fixed order, with a minimum delay between groups. Some channels are plain and have five control lines each. The last channel is an extended one: it adds a regulator reset, a termination reset, a DLL reset and a calibration/bias enable. Its release sequence includes two waits that are counted in ticks of a slow internal oscillator.

A request is accepted only when the source-select input gives control to this sequencer. Software or a power manager raises the freeze or the thaw request, watches `busy`, and waits for the one-cycle `done` pulse. Per-channel status bits report which channels are frozen. The plain channels are handled in ascending order, and the extended channel comes last. A status bit changes only when that channel's own sequence has finished.

Every nanosecond minimum is set as a parameter and converted to system-clock cycles, rounding up. With the defaults (10 ns clock, 20 ns and 40 ns gaps) this gives 2 cycles for a plain-channel gap and 4 cycles for an extended-channel gap. The oscillator waits count pulses on `osc_tick`.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, `frozen` is all ones and `busy` and `done` are low. Every plain-channel output is 0, so each active-low control is asserted and config-done is low. On the extended channel, the active-low controls and config-done are 0, regulator reset, termination reset and DLL reset are 1, and calibration enable is 0.
- R2: Freezing a plain channel drives slew, weak-pullup and tristate low in the same cycle. At least 2 cycles later, bus-hold and config-done go low together.
- R3: Thawing a plain channel first raises bus-hold and config-done together. At least 2 cycles later, weak-pullup and tristate rise together. At least 2 cycles after that, slew rises.
- R4: Freezing the extended channel runs three steps, each at least 4 cycles apart. Step 1 drives slew, weak-pullup and tristate low. Step 2 drives bus-hold and config-done low and raises both reset outputs (regulator and termination). Step 3 drops calibration enable and raises DLL reset.
- R5: Thawing the extended channel runs these steps in order:
  - DLL reset falls.
  - At least 4 cycles later, calibration enable rises.
  - After at least 1000 oscillator ticks, bus-hold and config-done rise and termination reset falls, all together.
  - After at least 33 ticks, weak-pullup and tristate rise.
  - At least 4 cycles later, regulator reset falls.
  - At least 4 cycles later, slew rises.
- R6: Channels are processed in ascending index order, and the extended channel (highest index) is last. A channel's `frozen` bit (1 = frozen) changes no earlier than its own final step, and before the next channel begins.
- R7: When a request is accepted, `busy` goes high on the next cycle and stays high until the sequence ends. `done` then pulses high for exactly one cycle, with `busy` low. `busy` and `done` are never high together. When both requests are high at once, freeze wins.
- R8: A request for the state all channels are already in gives a `done` pulse on the cycle after the request is sampled. It never raises `busy` and changes no output.
- R9: A freeze or thaw request that arrives while `busy` is high is ignored. The running sequence completes unchanged, and no second sequence follows.
- R10: While `seq_sel` is low, requests are ignored. `busy` and `done` stay low and no output changes.
- R11: While the sequencer is idle, every control output and status bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_sel | input | 1 | 1 gives pad control to this sequencer |
| osc_tick | input | 1 | One-cycle pulse per internal-oscillator period |
| freeze_req | input | 1 | Request to freeze all channels |
| thaw_req | input | 1 | Request to thaw all channels |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| frozen | output | NUM_SIMPLE+1 | Per-channel status, 1 = frozen |
| s_slew_n | output | NUM_SIMPLE | Plain channels, active-low slew control |
| s_wkpu_n | output | NUM_SIMPLE | Plain channels, active-low weak pullup |
| s_tri_n | output | NUM_SIMPLE | Plain channels, active-low tristate |
| s_bhold_n | output | NUM_SIMPLE | Plain channels, active-low bus-hold |
| s_cfg_done | output | NUM_SIMPLE | Plain channels, config-done |
| x_slew_n | output | 1 | Extended channel, active-low slew control |
| x_wkpu_n | output | 1 | Extended channel, active-low weak pullup |
| x_tri_n | output | 1 | Extended channel, active-low tristate |
| x_bhold_n | output | 1 | Extended channel, active-low bus-hold |
| x_cfg_done | output | 1 | Extended channel, config-done |
| x_reg_rst | output | 1 | Extended channel, regulator reset |
| x_term_rst | output | 1 | Extended channel, termination reset |
| x_dll_rst | output | 1 | Extended channel, DLL reset |
| x_cal_en | output | 1 | Extended channel, calibration/bias enable |

## Verification
A wrong step index or channel index shows up at the pads at once. A control line moves out of order, moves on the wrong channel, or moves together with a group it should not belong to, and this is visible on the same edge at which the step is applied. A timer loaded with the wrong value, or counting the wrong source, shows as a gap between two pad changes that is shorter than its minimum. This appears one step later, and the oscillator count between the two changes makes it measurable. A faulty status or handshake state appears as a stale `frozen` bit, a missing or doubled `done` pulse, or `busy` that never rises. These show within a cycle of the request or at the end of the sequence.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACT,
      ST_WAIT,
      ST_FIN
   } iofrz_state_e;

   typedef struct packed {
      logic slew_n;
      logic wkpu_n;
      logic tri_n;
      logic bhold_n;
      logic cfg_done;
   } pad_ctl_t;

   typedef struct packed {
      pad_ctl_t pad;
      logic     reg_rst;
      logic     term_rst;
      logic     dll_rst;
      logic     cal_en;
   } ext_ctl_t;

   localparam pad_ctl_t PAD_FROZEN = '{slew_n: 1'b0, wkpu_n: 1'b0, tri_n: 1'b0,
                                       bhold_n: 1'b0, cfg_done: 1'b0};

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/iofrz_timer.sv
// Wait counter: counts system cycles or oscillator ticks down to zero.
module iofrz_timer #(
   parameter int TW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_osc,
   input  logic [TW-1:0] load_val,
   input  logic          osc_tick,
   output logic          expired
);
   logic [TW-1:0] cnt;
   logic          osc_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         osc_mode <= 1'b0;
      end else if (load) begin
         cnt      <= load_val;
         osc_mode <= load_osc;
      end else if (cnt != '0 && (!osc_mode || osc_tick)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

   AST_TMR_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && osc_mode && !osc_tick) |=> $stable(cnt)); // R5

endmodule

// File: rtl/iofrz_simple_chan.sv
// Plain channel: five pad controls, updated only on an applied step.
module iofrz_simple_chan import iofrz_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       apply,
   input  logic       thaw,
   input  logic [2:0] step,
   output pad_ctl_t   ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= PAD_FROZEN;
      end else if (apply) begin
         if (!thaw) begin
            case (step)
               3'd0: begin
                  ctl.slew_n <= 1'b0;
                  ctl.wkpu_n <= 1'b0;
                  ctl.tri_n  <= 1'b0;
               end
               default: begin
                  ctl.bhold_n  <= 1'b0;
                  ctl.cfg_done <= 1'b0;
               end
            endcase
         end else begin
            case (step)
               3'd0: begin
                  ctl.bhold_n  <= 1'b1;
                  ctl.cfg_done <= 1'b1;
               end
               3'd1: begin
                  ctl.wkpu_n <= 1'b1;
                  ctl.tri_n  <= 1'b1;
               end
               default: ctl.slew_n <= 1'b1;
            endcase
         end
      end
   end

   AST_S_HOLD_AFTER_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl.bhold_n) |-> (!ctl.slew_n && !ctl.wkpu_n && !ctl.tri_n)); // R2
   AST_S_SLEW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.slew_n) |-> (ctl.wkpu_n && ctl.tri_n && ctl.bhold_n)); // R3

endmodule

// File: rtl/iofrz_ext_chan.sv
// Extended channel: pad controls plus regulator/termination/DLL/calibration.
module iofrz_ext_chan import iofrz_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       apply,
   input  logic       thaw,
   input  logic [2:0] step,
   output ext_ctl_t   ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl.pad      <= PAD_FROZEN;
         ctl.reg_rst  <= 1'b1;
         ctl.term_rst <= 1'b1;
         ctl.dll_rst  <= 1'b1;
         ctl.cal_en   <= 1'b0;
      end else if (apply) begin
         if (!thaw) begin
            case (step)
               3'd0: begin
                  ctl.pad.slew_n <= 1'b0;
                  ctl.pad.wkpu_n <= 1'b0;
                  ctl.pad.tri_n  <= 1'b0;
               end
               3'd1: begin
                  ctl.pad.bhold_n  <= 1'b0;
                  ctl.pad.cfg_done <= 1'b0;
                  ctl.reg_rst      <= 1'b1;
                  ctl.term_rst     <= 1'b1;
               end
               default: begin
                  ctl.cal_en  <= 1'b0;
                  ctl.dll_rst <= 1'b1;
               end
            endcase
         end else begin
            case (step)
               3'd0: ctl.dll_rst <= 1'b0;
               3'd1: ctl.cal_en  <= 1'b1;
               3'd2: begin
                  ctl.pad.bhold_n  <= 1'b1;
                  ctl.pad.cfg_done <= 1'b1;
                  ctl.term_rst     <= 1'b0;
               end
               3'd3: begin
                  ctl.pad.wkpu_n <= 1'b1;
                  ctl.pad.tri_n  <= 1'b1;
               end
               3'd4: ctl.reg_rst <= 1'b0;
               default: ctl.pad.slew_n <= 1'b1;
            endcase
         end
      end
   end

   AST_X_CAL_AFTER_DLL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.cal_en) |-> !ctl.dll_rst); // R5
   AST_X_HOLD_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.pad.bhold_n) |-> ctl.cal_en); // R5
   AST_X_DLL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.dll_rst) |-> (!ctl.pad.bhold_n && ctl.reg_rst && ctl.term_rst)); // R4

endmodule

// File: rtl/io_freeze_seq.sv
// Freeze/thaw sequencer: walks plain channels in ascending order, then the
// extended channel. Freeze wins when both requests are high.
module io_freeze_seq import iofrz_pkg::*; #(
   parameter int NUM_SIMPLE     = 3,
   parameter int CLK_PERIOD_NS  = 10,
   parameter int SIMPLE_GAP_NS  = 20,
   parameter int EXT_GAP_NS     = 40,
   parameter int LONG_OSC_CYC   = 1000,
   parameter int SHORT_OSC_CYC  = 33
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  seq_sel,
   input  logic                  osc_tick,
   input  logic                  freeze_req,
   input  logic                  thaw_req,
   output logic                  busy,
   output logic                  done,
   output logic [NUM_SIMPLE:0]   frozen,
   output logic [NUM_SIMPLE-1:0] s_slew_n,
   output logic [NUM_SIMPLE-1:0] s_wkpu_n,
   output logic [NUM_SIMPLE-1:0] s_tri_n,
   output logic [NUM_SIMPLE-1:0] s_bhold_n,
   output logic [NUM_SIMPLE-1:0] s_cfg_done,
   output logic                  x_slew_n,
   output logic                  x_wkpu_n,
   output logic                  x_tri_n,
   output logic                  x_bhold_n,
   output logic                  x_cfg_done,
   output logic                  x_reg_rst,
   output logic                  x_term_rst,
   output logic                  x_dll_rst,
   output logic                  x_cal_en
);
   localparam int NCH       = NUM_SIMPLE + 1;
   localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int GAP_S_CYC = ceil_div(SIMPLE_GAP_NS, CLK_PERIOD_NS);
   localparam int GAP_X_CYC = ceil_div(EXT_GAP_NS, CLK_PERIOD_NS);
   localparam int MAX_WAIT  = max2(max2(GAP_S_CYC, GAP_X_CYC), max2(LONG_OSC_CYC, SHORT_OSC_CYC));
   localparam int TW        = $clog2(MAX_WAIT + 1);
   localparam logic [CH_W-1:0] EXT_IDX = CH_W'(NUM_SIMPLE);

   if (NUM_SIMPLE < 1) begin : g_chk_simple
      $error("NUM_SIMPLE must be at least 1");
   end
   if (CLK_PERIOD_NS < 1 || SIMPLE_GAP_NS < 1 || EXT_GAP_NS < 1) begin : g_chk_ns
      $error("clock period and gaps must be positive");
   end
   if (LONG_OSC_CYC < 1 || SHORT_OSC_CYC < 1) begin : g_chk_osc
      $error("oscillator waits must be positive");
   end

   iofrz_state_e    state;
   logic [CH_W-1:0] ch;
   logic [2:0]      step;
   logic            thaw_r;
   logic            apply;
   logic            st_last;
   logic            st_osc;
   logic [TW-1:0]   st_wait;
   logic            tmr_expired;
   logic            any_req;
   logic            want_thaw;
   logic            already;

   assign any_req   = seq_sel && (freeze_req || thaw_req);
   assign want_thaw = !freeze_req;
   assign already   = want_thaw ? (frozen == '0) : (&frozen);
   assign apply     = (state == ST_ACT);
   assign busy      = (state == ST_ACT) || (state == ST_WAIT);
   assign done      = (state == ST_FIN);

   // Step plan: wait that follows each step, and which step ends a channel.
   always_comb begin
      st_last = 1'b0;
      st_osc  = 1'b0;
      st_wait = '0;
      if (ch == EXT_IDX) begin
         if (thaw_r) begin
            case (step)
               3'd0, 3'd3, 3'd4: st_wait = TW'(GAP_X_CYC);
               3'd1: begin st_wait = TW'(LONG_OSC_CYC);  st_osc = 1'b1; end
               3'd2: begin st_wait = TW'(SHORT_OSC_CYC); st_osc = 1'b1; end
               default: st_last = 1'b1;
            endcase
         end else begin
            case (step)
               3'd0, 3'd1: st_wait = TW'(GAP_X_CYC);
               default:    st_last = 1'b1;
            endcase
         end
      end else if (thaw_r) begin
         case (step)
            3'd0, 3'd1: st_wait = TW'(GAP_S_CYC);
            default:    st_last = 1'b1;
         endcase
      end else begin
         case (step)
            3'd0:    st_wait = TW'(GAP_S_CYC);
            default: st_last = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ch     <= '0;
         step   <= '0;
         thaw_r <= 1'b0;
         frozen <= '1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (any_req) begin
                  if (already) begin
                     state <= ST_FIN;
                  end else begin
                     state  <= ST_ACT;
                     thaw_r <= want_thaw;
                     ch     <= '0;
                     step   <= '0;
                  end
               end
            end
            ST_ACT: begin
               if (st_last) begin
                  frozen[ch] <= !thaw_r;
                  step       <= '0;
                  if (ch == EXT_IDX) begin
                     state <= ST_FIN;
                  end else begin
                     ch <= ch + 1'b1;
                  end
               end else begin
                  step  <= step + 1'b1;
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tmr_expired) state <= ST_ACT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   iofrz_timer #(.TW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (apply && !st_last),
      .load_osc (st_osc),
      .load_val (st_wait),
      .osc_tick (osc_tick),
      .expired  (tmr_expired)
   );

   for (genvar gi = 0; gi < NUM_SIMPLE; gi++) begin : g_simple
      pad_ctl_t ctl;
      iofrz_simple_chan i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .apply (apply && (ch == CH_W'(gi))),
         .thaw  (thaw_r),
         .step  (step),
         .ctl   (ctl)
      );
      assign s_slew_n[gi]   = ctl.slew_n;
      assign s_wkpu_n[gi]   = ctl.wkpu_n;
      assign s_tri_n[gi]    = ctl.tri_n;
      assign s_bhold_n[gi]  = ctl.bhold_n;
      assign s_cfg_done[gi] = ctl.cfg_done;
   end

   ext_ctl_t xctl;
   iofrz_ext_chan i_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .apply (apply && (ch == EXT_IDX)),
      .thaw  (thaw_r),
      .step  (step),
      .ctl   (xctl)
   );
   assign x_slew_n   = xctl.pad.slew_n;
   assign x_wkpu_n   = xctl.pad.wkpu_n;
   assign x_tri_n    = xctl.pad.tri_n;
   assign x_bhold_n  = xctl.pad.bhold_n;
   assign x_cfg_done = xctl.pad.cfg_done;
   assign x_reg_rst  = xctl.reg_rst;
   assign x_term_rst = xctl.term_rst;
   assign x_dll_rst  = xctl.dll_rst;
   assign x_cal_en   = xctl.cal_en;

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_STATUS_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frozen) |-> $past(state == ST_ACT)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> ($stable(s_slew_n) && $stable(s_bhold_n) && $stable(s_tri_n)
                              && $stable(x_dll_rst) && $stable(x_cal_en) && $stable(frozen))); // R11
   AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !tmr_expired) |=> (state == ST_WAIT || state == ST_ACT)); // R9

endmodule

// File: tb/test_io_freeze_seq.sv
module test_io_freeze_seq;
   localparam int CLK_NS = 10;
   localparam int GAP_S  = (20 + CLK_NS - 1) / CLK_NS;
   localparam int GAP_X  = (40 + CLK_NS - 1) / CLK_NS;
   localparam int LONG_T = 1000;
   localparam int SHORT_T = 33;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_sel = 1'b1;
   logic osc_tick = 1'b0;
   logic freeze_req = 1'b0;
   logic thaw_req = 1'b0;
   logic busy, done;
   logic [3:0] frozen;
   logic [2:0] s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done;
   logic x_slew_n, x_wkpu_n, x_tri_n, x_bhold_n, x_cfg_done;
   logic x_reg_rst, x_term_rst, x_dll_rst, x_cal_en;

   io_freeze_seq i_io_freeze_seq (
      .clk(clk), .rst_n(rst_n), .seq_sel(seq_sel), .osc_tick(osc_tick),
      .freeze_req(freeze_req), .thaw_req(thaw_req), .busy(busy), .done(done),
      .frozen(frozen), .s_slew_n(s_slew_n), .s_wkpu_n(s_wkpu_n), .s_tri_n(s_tri_n),
      .s_bhold_n(s_bhold_n), .s_cfg_done(s_cfg_done), .x_slew_n(x_slew_n),
      .x_wkpu_n(x_wkpu_n), .x_tri_n(x_tri_n), .x_bhold_n(x_bhold_n),
      .x_cfg_done(x_cfg_done), .x_reg_rst(x_reg_rst), .x_term_rst(x_term_rst),
      .x_dll_rst(x_dll_rst), .x_cal_en(x_cal_en)
   );

   always #(CLK_NS/2) clk = ~clk;

   int cyc = 0;
   int oscn = 0;
   int nchk = 0;
   int nfail = 0;
   always @(posedge clk) begin
      cyc++;
      if (osc_tick) oscn++;
   end
   always @(negedge clk) osc_tick <= (cyc % 2 == 0);

   // Change monitor. x index: 0 slew,1 wkpu,2 tri,3 bhold,4 cfg,5 reg,6 term,7 dll,8 cal
   int ts_slew[3], ts_wkpu[3], ts_tri[3], ts_bh[3], ts_cfg[3], ts_frz[4];
   int xt[9], xo[9];
   int chg = 0, done_hi = 0, busy_hi = 0, both_hi = 0, done_long = 0;
   logic [2:0] p_slew, p_wkpu, p_tri, p_bh, p_cfg;
   logic [8:0] p_x;
   logic [3:0] p_frz;
   logic p_done = 1'b0;
   bit mon_on = 1'b0;
   wire [8:0] xv = {x_cal_en, x_dll_rst, x_term_rst, x_reg_rst, x_cfg_done,
                    x_bhold_n, x_tri_n, x_wkpu_n, x_slew_n};

   always @(negedge clk) begin
      if (mon_on) begin
         for (int i = 0; i < 3; i++) begin
            if (s_slew_n[i] !== p_slew[i]) begin ts_slew[i] = cyc; chg++; end
            if (s_wkpu_n[i] !== p_wkpu[i]) begin ts_wkpu[i] = cyc; chg++; end
            if (s_tri_n[i]  !== p_tri[i])  begin ts_tri[i]  = cyc; chg++; end
            if (s_bhold_n[i] !== p_bh[i])  begin ts_bh[i]   = cyc; chg++; end
            if (s_cfg_done[i] !== p_cfg[i]) begin ts_cfg[i] = cyc; chg++; end
         end
         for (int j = 0; j < 9; j++)
            if (xv[j] !== p_x[j]) begin xt[j] = cyc; xo[j] = oscn; chg++; end
         for (int k = 0; k < 4; k++)
            if (frozen[k] !== p_frz[k]) begin ts_frz[k] = cyc; chg++; end
         if (done) done_hi++;
         if (busy) busy_hi++;
         if (done && busy) both_hi++;
         if (done && p_done) done_long++;
      end
      p_slew = s_slew_n; p_wkpu = s_wkpu_n; p_tri = s_tri_n; p_bh = s_bhold_n;
      p_cfg = s_cfg_done; p_x = xv; p_frz = frozen; p_done = done;
      mon_on = rst_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step_clk();
      @(posedge clk); #1;
   endtask

   task automatic pulse_req(input bit frz);
      step_clk();
      if (frz) freeze_req = 1'b1; else thaw_req = 1'b1;
      step_clk();
      freeze_req = 1'b0;
      thaw_req = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int n = 0; n < 20000; n++) begin
         if (done) begin ok = 1'b1; break; end
         step_clk();
      end
   endtask

   task automatic t_reset();
      chk(frozen == 4'hF, "R1", "frozen after reset", frozen, 15);
      chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
      chk({s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done} == '0, "R1",
          "plain outputs after reset", {s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done}, 0);
      chk(xv == 9'b011100000, "R1", "extended outputs after reset", xv, 9'b011100000);
   endtask

   task automatic t_idle_hold();
      int c0 = chg;
      repeat (50) step_clk();
      chk(chg == c0, "R11", "output changes while idle", chg - c0, 0);
   endtask

   task automatic t_same_state(input bit frz);
      int c0 = chg, b0 = busy_hi;
      pulse_req(frz);
      chk(done == 1'b1, "R8", "done on cycle after request", done, 1);
      step_clk();
      chk(done == 1'b0, "R8", "done width", done, 0);
      repeat (5) step_clk();
      chk(busy_hi == b0, "R8", "busy cycles", busy_hi - b0, 0);
      chk(chg == c0, "R8", "output changes", chg - c0, 0);
   endtask

   task automatic t_srcsel();
      int c0 = chg, b0 = busy_hi, d0 = done_hi;
      seq_sel = 1'b0;
      pulse_req(1'b0);
      repeat (20) step_clk();
      seq_sel = 1'b1;
      chk(busy_hi == b0 && done_hi == d0, "R10", "busy+done cycles with source off",
          busy_hi - b0 + done_hi - d0, 0);
      chk(chg == c0 && frozen == 4'hF, "R10", "changes with source off", chg - c0, 0);
   endtask

   task automatic t_thaw();
      bit ok;
      pulse_req(1'b0);
      chk(busy == 1'b1, "R7", "busy after thaw accepted", busy, 1);
      wait_done(ok);
      chk(ok && !busy, "R7", "thaw completes with done, busy low", {ok, busy}, 2);
      step_clk();
      chk(!done && done_long == 0 && both_hi == 0, "R7", "done single cycle",
          done_long + both_hi + done, 0);
      chk(frozen == 4'h0, "R6", "status after thaw", frozen, 0);
      chk({s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done} == '1, "R3",
          "plain outputs thawed", {s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done}, 32767);
      for (int c = 0; c < 3; c++) begin
         chk(ts_bh[c] == ts_cfg[c] && ts_wkpu[c] == ts_tri[c], "R3", "grouped changes",
             ts_bh[c] - ts_cfg[c], 0);
         chk(ts_wkpu[c] - ts_bh[c] >= GAP_S, "R3", "gap hold->pullup", ts_wkpu[c] - ts_bh[c], GAP_S);
         chk(ts_slew[c] - ts_wkpu[c] >= GAP_S, "R3", "gap pullup->slew", ts_slew[c] - ts_wkpu[c], GAP_S);
         chk(ts_frz[c] >= ts_slew[c], "R6", "status not before last step", ts_frz[c], ts_slew[c]);
         if (c < 2)
            chk(ts_bh[c+1] > ts_frz[c], "R6", "next channel after status", ts_bh[c+1], ts_frz[c] + 1);
      end
      chk(xt[7] > ts_frz[2], "R6", "extended channel starts last", xt[7], ts_frz[2] + 1);
      chk(xv == 9'b100011111, "R5", "extended outputs thawed", xv, 9'b100011111);
      chk(xt[8] - xt[7] >= GAP_X, "R5", "gap dll->cal", xt[8] - xt[7], GAP_X);
      chk(xt[3] == xt[4] && xt[3] == xt[6], "R5", "hold/cfg/term together", xt[3] - xt[6], 0);
      chk(xo[3] - xo[8] >= LONG_T, "R5", "osc ticks cal->hold", xo[3] - xo[8], LONG_T);
      chk(xt[1] == xt[2] && xo[1] - xo[3] >= SHORT_T, "R5", "osc ticks hold->pullup",
          xo[1] - xo[3], SHORT_T);
      chk(xt[5] - xt[1] >= GAP_X, "R5", "gap pullup->regulator", xt[5] - xt[1], GAP_X);
      chk(xt[0] - xt[5] >= GAP_X, "R5", "gap regulator->slew", xt[0] - xt[5], GAP_X);
      chk(ts_frz[3] >= xt[0], "R6", "extended status after last step", ts_frz[3], xt[0]);
   endtask

   task automatic t_freeze(input bit poke_thaw);
      bit ok;
      int b0;
      pulse_req(1'b1);
      chk(busy == 1'b1, "R7", "busy after freeze accepted", busy, 1);
      if (poke_thaw) begin
         repeat (3) step_clk();
         pulse_req(1'b0);
      end
      wait_done(ok);
      chk(ok, "R7", "freeze completes", ok, 1);
      step_clk();
      chk(frozen == 4'hF, "R6", "status after freeze", frozen, 15);
      chk({s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done} == '0, "R2",
          "plain outputs frozen", {s_slew_n, s_wkpu_n, s_tri_n, s_bhold_n, s_cfg_done}, 0);
      chk(xv == 9'b011100000, "R4", "extended outputs frozen", xv, 9'b011100000);
      for (int c = 0; c < 3; c++) begin
         chk(ts_slew[c] == ts_wkpu[c] && ts_slew[c] == ts_tri[c] && ts_bh[c] == ts_cfg[c],
             "R2", "grouped changes", ts_slew[c] - ts_tri[c], 0);
         chk(ts_bh[c] - ts_slew[c] >= GAP_S, "R2", "gap isolate->hold", ts_bh[c] - ts_slew[c], GAP_S);
         if (c < 2)
            chk(ts_slew[c+1] > ts_frz[c], "R6", "next channel after status", ts_slew[c+1], ts_frz[c] + 1);
      end
      chk(xt[0] > ts_frz[2], "R6", "extended channel last", xt[0], ts_frz[2] + 1);
      chk(xt[0] == xt[1] && xt[0] == xt[2], "R4", "step 1 grouped", xt[0] - xt[2], 0);
      chk(xt[3] == xt[4] && xt[3] == xt[5] && xt[3] == xt[6], "R4", "step 2 grouped", xt[3] - xt[5], 0);
      chk(xt[3] - xt[0] >= GAP_X, "R4", "gap step1->step2", xt[3] - xt[0], GAP_X);
      chk(xt[7] == xt[8] && xt[7] - xt[3] >= GAP_X, "R4", "gap step2->step3", xt[7] - xt[3], GAP_X);
      if (poke_thaw) begin
         b0 = busy_hi;
         repeat (20) step_clk();
         chk(busy_hi == b0 && frozen == 4'hF, "R9", "thaw during busy ignored", busy_hi - b0, 0);
      end
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step_clk();
      t_reset();
      t_idle_hold();
      t_same_state(1'b1);
      t_srcsel();
      t_thaw();
      t_same_state(1'b0);
      t_idle_hold();
      t_freeze(1'b0);
      t_thaw();
      t_freeze(1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule